// File: doc/BRIEF.md
# Burst Beat Order Generator

This block turns one burst request into the order in which the beats of a burst are transferred. A start pulse captures the starting column bits, the ordering mode (sequential or interleaved), the direction (read or write) and whether the burst is cut to half length. The block then walks through a fixed number of beat slots, `2**IDX_W` of them, which is eight by default. In each slot it presents a registered beat index, a valid flag and a drive-enable flag. It raises a done pulse together with the last slot.

Read bursts follow the requested start column. Sequential order rotates inside the half-burst that holds the start column and then does the same rotation in the other half. Interleaved order is the start column XOR the slot number. Write bursts ignore the start column and use a fixed ascending order. The one exception is a chopped write, whose top column bit picks the lower or upper half. A chopped burst still takes every slot. Its second half carries no valid beat and nothing is driven there.

A start pulse that arrives while a burst is running has no effect on that burst, and the block flags it. The block holds no data of its own. A strobe generator and a data path consume its outputs.

Top module: `burst_order_gen`

## Requirements
- R1: While reset is held, beat_idx_o, beat_vld_o, drv_en_o, done_o and overrun_o are all zero.
- R2: A full sequential read starting at column s gives, in slot k (0..7), the index ((s XOR k) AND 4) OR ((s + k) AND 3). For example, s=5 gives 5,6,7,4,1,2,3,0.
- R3: A full interleaved read (ilv_i=1) starting at column s gives s XOR k in slot k. For example, s=3 gives 3,2,1,0,7,6,5,4.
- R4: A chopped read gives, in slots 0..3, the same indices as the unchopped order with drv_en_o high. In slots 4..7, beat_vld_o and drv_en_o are low. In every slot without a valid beat, beat_idx_o is 0.
- R5: A full write (wr_i=1) gives index k in slot k for every start column and either ordering mode, with drv_en_o low throughout.
- R6: A chopped write gives (s AND 4) OR k in slots 0..3, ignoring s bits 1:0 and the ordering mode. Its slots 4..7 carry no valid beat.
- R7: When start_i is sampled high at edge E0 with no burst running, the slot-0 beat is visible after edge E1. Slot k is visible after edge E(k+1). Eight slots are produced for both chopped and full bursts.
- R8: done_o is high for exactly one cycle, in the same cycle as the slot-7 output of every burst.
- R9: A start_i sampled high at any edge from E1 to E8 of a running burst is ignored, and overrun_o is high for the one cycle after that edge.
- R10: col_i, ilv_i, wr_i and chop_i are captured at the accepting edge. Changes to them during a burst do not alter that burst's outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Burst start pulse |
| col_i | input | IDX_W | Starting column bits |
| ilv_i | input | 1 | 1 = interleaved order, 0 = sequential |
| wr_i | input | 1 | 1 = write burst, 0 = read burst |
| chop_i | input | 1 | 1 = half-length (chopped) burst |
| beat_idx_o | output | IDX_W | Beat index for the current slot |
| beat_vld_o | output | 1 | Slot carries a valid beat |
| drv_en_o | output | 1 | Outputs are driven in this slot (low = tri-state) |
| done_o | output | 1 | Pulse with the last slot of a burst |
| overrun_o | output | 1 | Pulse after an ignored start |

## Verification
The bench builds the block with the default IDX_W of 3, so each burst has eight slots and the whole input space is small. That space is 8 start columns × 2 ordering modes × 2 directions × 2 lengths, which makes 64 bursts. Every one of them is swept, and index, valid, drive-enable, done and overrun are compared in every slot against values computed arithmetically. Further bursts inject a second start in the first, a middle and the last slot while flipping all the configuration inputs. This covers the ignored-start and capture boundaries.

// File: rtl/burst_order_pkg.sv
package burst_order_pkg;

   typedef enum logic {
      ORD_SEQ = 1'b0,
      ORD_ILV = 1'b1
   } ord_e;

   typedef enum logic {
      DIR_RD = 1'b0,
      DIR_WR = 1'b1
   } dir_e;

   typedef struct packed {
      ord_e ord;
      dir_e dir;
      logic chop;
   } bmode_t;

endpackage

// File: rtl/burst_order_ctrl.sv
module burst_order_ctrl
   import burst_order_pkg::*;
#(
   parameter int unsigned IDX_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [IDX_W-1:0] col_i,
   input  bmode_t           mode_i,
   output logic             act_o,
   output logic [IDX_W-1:0] slot_o,
   output logic [IDX_W-1:0] col_o,
   output bmode_t           mode_o,
   output logic             ovr_o
);

   localparam logic [IDX_W-1:0] SLOT_LAST = '1;

   logic             act_q;
   logic [IDX_W-1:0] slot_q;
   logic [IDX_W-1:0] col_q;
   bmode_t           mode_q;
   logic             ovr_q;
   logic             accept;

   assign accept = start_i & ~act_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         act_q  <= 1'b0;
         slot_q <= '0;
         col_q  <= '0;
         mode_q <= '{ord: ORD_SEQ, dir: DIR_RD, chop: 1'b0};
         ovr_q  <= 1'b0;
      end else begin
         ovr_q <= start_i & act_q;
         if (accept) begin
            act_q  <= 1'b1;
            slot_q <= '0;
            col_q  <= col_i;
            mode_q <= mode_i;
         end else if (act_q) begin
            if (slot_q == SLOT_LAST) begin
               act_q  <= 1'b0;
               slot_q <= '0;
            end else begin
               slot_q <= slot_q + 1'b1;
            end
         end
      end
   end

   assign act_o  = act_q;
   assign slot_o = slot_q;
   assign col_o  = col_q;
   assign mode_o = mode_q;
   assign ovr_o  = ovr_q;

endmodule

// File: rtl/burst_order_map.sv
module burst_order_map
   import burst_order_pkg::*;
#(
   parameter int unsigned IDX_W = 3
) (
   input  logic             act_i,
   input  logic [IDX_W-1:0] slot_i,
   input  logic [IDX_W-1:0] col_i,
   input  bmode_t           mode_i,
   output logic [IDX_W-1:0] idx_o,
   output logic             vld_o,
   output logic             drv_o,
   output logic             last_o
);

   localparam int unsigned    LW        = IDX_W - 1;
   localparam logic [IDX_W-1:0] SLOT_LAST = '1;

   logic [IDX_W-1:0] ilv_idx;
   logic [IDX_W-1:0] seq_idx;
   logic [IDX_W-1:0] wch_idx;
   logic [LW-1:0]    seq_lo;
   logic [IDX_W-1:0] raw_idx;
   logic             in_upper;

   // interleaved: bitwise xor of start and slot; chopped write: top bit from column
   for (genvar g = 0; g < IDX_W; g++) begin : g_bit
      assign ilv_idx[g] = col_i[g] ^ slot_i[g];
      if (g == IDX_W - 1) begin : g_top
         assign wch_idx[g] = col_i[g];
      end else begin : g_low
         assign wch_idx[g] = slot_i[g];
      end
   end

   // sequential: rotate inside the half, top bit flips for second half
   assign seq_lo  = col_i[LW-1:0] + slot_i[LW-1:0];
   assign seq_idx = {col_i[IDX_W-1] ^ slot_i[IDX_W-1], seq_lo};

   assign in_upper = slot_i[IDX_W-1];

   always_comb begin
      if (mode_i.dir == DIR_WR) begin
         raw_idx = mode_i.chop ? wch_idx : slot_i;
      end else if (mode_i.ord == ORD_ILV) begin
         raw_idx = ilv_idx;
      end else begin
         raw_idx = seq_idx;
      end
   end

   assign vld_o  = act_i & ~(mode_i.chop & in_upper);
   assign drv_o  = vld_o & (mode_i.dir == DIR_RD);
   assign idx_o  = vld_o ? raw_idx : '0;
   assign last_o = act_i & (slot_i == SLOT_LAST);

endmodule

// File: rtl/burst_order_oreg.sv
module burst_order_oreg #(
   parameter int unsigned IDX_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] idx_i,
   input  logic             vld_i,
   input  logic             drv_i,
   input  logic             last_i,
   output logic [IDX_W-1:0] idx_o,
   output logic             vld_o,
   output logic             drv_o,
   output logic             done_o
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         idx_o  <= '0;
         vld_o  <= 1'b0;
         drv_o  <= 1'b0;
         done_o <= 1'b0;
      end else begin
         idx_o  <= idx_i;
         vld_o  <= vld_i;
         drv_o  <= drv_i;
         done_o <= last_i;
      end
   end

endmodule

// File: rtl/burst_order_gen.sv
module burst_order_gen
   import burst_order_pkg::*;
#(
   parameter int unsigned IDX_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [IDX_W-1:0] col_i,
   input  logic             ilv_i,
   input  logic             wr_i,
   input  logic             chop_i,
   output logic [IDX_W-1:0] beat_idx_o,
   output logic             beat_vld_o,
   output logic             drv_en_o,
   output logic             done_o,
   output logic             overrun_o
);

   if (IDX_W < 2) begin : g_bad_width
      $error("burst_order_gen: IDX_W must be at least 2");
   end

   bmode_t           mode_in;
   bmode_t           mode_q;
   logic             act;
   logic [IDX_W-1:0] slot;
   logic [IDX_W-1:0] col_q;
   logic [IDX_W-1:0] idx_c;
   logic             vld_c;
   logic             drv_c;
   logic             last_c;

   assign mode_in.ord  = ilv_i ? ORD_ILV : ORD_SEQ;
   assign mode_in.dir  = wr_i  ? DIR_WR  : DIR_RD;
   assign mode_in.chop = chop_i;

   burst_order_ctrl #(.IDX_W(IDX_W)) u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (start_i),
      .col_i   (col_i),
      .mode_i  (mode_in),
      .act_o   (act),
      .slot_o  (slot),
      .col_o   (col_q),
      .mode_o  (mode_q),
      .ovr_o   (overrun_o)
   );

   burst_order_map #(.IDX_W(IDX_W)) u_map (
      .act_i  (act),
      .slot_i (slot),
      .col_i  (col_q),
      .mode_i (mode_q),
      .idx_o  (idx_c),
      .vld_o  (vld_c),
      .drv_o  (drv_c),
      .last_o (last_c)
   );

   burst_order_oreg #(.IDX_W(IDX_W)) u_oreg (
      .clk    (clk),
      .rst_n  (rst_n),
      .idx_i  (idx_c),
      .vld_i  (vld_c),
      .drv_i  (drv_c),
      .last_i (last_c),
      .idx_o  (beat_idx_o),
      .vld_o  (beat_vld_o),
      .drv_o  (drv_en_o),
      .done_o (done_o)
   );

endmodule

// File: rtl/burst_order_gen_chk.sv
module burst_order_gen_chk #(
   parameter int unsigned IDX_W = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start_i,
   input logic [IDX_W-1:0] col_i,
   input logic             wr_i,
   input logic             chop_i,
   input logic [IDX_W-1:0] beat_idx_o,
   input logic             beat_vld_o,
   input logic             drv_en_o,
   input logic             done_o,
   input logic             overrun_o
);

   localparam logic [IDX_W-1:0] M_LAST = '1;

   logic             m_busy;
   logic [IDX_W-1:0] m_cnt;
   logic             o_act;
   logic [IDX_W-1:0] o_slot;
   logic             m_wr;
   logic             m_chop;
   logic             m_ctop;
   logic             m_ign;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         m_busy <= 1'b0;
         m_cnt  <= '0;
         o_act  <= 1'b0;
         o_slot <= '0;
         m_wr   <= 1'b0;
         m_chop <= 1'b0;
         m_ctop <= 1'b0;
         m_ign  <= 1'b0;
      end else begin
         o_act  <= m_busy;
         o_slot <= m_cnt;
         m_ign  <= start_i & m_busy;
         if (start_i && !m_busy) begin
            m_busy <= 1'b1;
            m_cnt  <= '0;
            m_wr   <= wr_i;
            m_chop <= chop_i;
            m_ctop <= col_i[IDX_W-1];
         end else if (m_busy) begin
            if (m_cnt == M_LAST) begin
               m_busy <= 1'b0;
               m_cnt  <= '0;
            end else begin
               m_cnt <= m_cnt + 1'b1;
            end
         end
      end
   end

   // R8
   done_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (o_act && o_slot == M_LAST));

   // R7
   vld_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
      beat_vld_o |-> o_act);

   // R4
   drv_needs_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
      drv_en_o |-> beat_vld_o);

   // R4
   idle_idx_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !beat_vld_o |-> (beat_idx_o == '0));

   // R4
   chop_upper_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (o_act && m_chop && o_slot[IDX_W-1]) |-> !beat_vld_o);

   // R5
   write_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (o_act && m_wr) |-> !drv_en_o);

   // R5
   write_full_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (beat_vld_o && m_wr && !m_chop) |-> (beat_idx_o == o_slot));

   // R6
   write_chop_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (beat_vld_o && m_wr && m_chop) |-> (beat_idx_o[IDX_W-1] == m_ctop));

   // R9
   overrun_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      overrun_o |-> m_ign);

endmodule

bind burst_order_gen burst_order_gen_chk #(.IDX_W(IDX_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .start_i    (start_i),
   .col_i      (col_i),
   .wr_i       (wr_i),
   .chop_i     (chop_i),
   .beat_idx_o (beat_idx_o),
   .beat_vld_o (beat_vld_o),
   .drv_en_o   (drv_en_o),
   .done_o     (done_o),
   .overrun_o  (overrun_o)
);

// File: tb/burst_order_gen_tb.sv
module burst_order_gen_tb;

   localparam int IW    = 3;
   localparam int BEATS = 1 << IW;
   localparam int HALF  = BEATS / 2;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          start_i;
   logic [IW-1:0] col_i;
   logic          ilv_i;
   logic          wr_i;
   logic          chop_i;
   logic [IW-1:0] beat_idx_o;
   logic          beat_vld_o;
   logic          drv_en_o;
   logic          done_o;
   logic          overrun_o;

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   burst_order_gen #(.IDX_W(IW)) u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (start_i),
      .col_i      (col_i),
      .ilv_i      (ilv_i),
      .wr_i       (wr_i),
      .chop_i     (chop_i),
      .beat_idx_o (beat_idx_o),
      .beat_vld_o (beat_vld_o),
      .drv_en_o   (drv_en_o),
      .done_o     (done_o),
      .overrun_o  (overrun_o)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int exp_idx(int s, int k, bit ilv, bit wr, bit chop);
      if (wr) return chop ? ((s & HALF) | k) : k;
      if (ilv) return s ^ k;
      return ((s ^ k) & HALF) | ((s + k) & (HALF - 1));
   endfunction

   // dis: slot at whose check a stray start (with flipped config) is driven; -1 none
   task automatic run(input int s, input bit ilv, input bit wr, input bit chop, input int dis);
      string tag;
      @(negedge clk);
      start_i = 1'b1; col_i = IW'(s); ilv_i = ilv; wr_i = wr; chop_i = chop;
      @(negedge clk);
      start_i = 1'b0;
      chk("R7 no beat before first slot", int'(beat_vld_o), 0);
      for (int k = 0; k < BEATS; k++) begin
         bit v;
         @(negedge clk);
         v = !(chop && k >= HALF);
         tag = wr ? (chop ? "R6 index" : "R5 index")
                  : (chop ? "R4 index" : (ilv ? "R3 index" : "R2 index"));
         chk("R7 valid", int'(beat_vld_o), int'(v));
         if (v) chk(tag, int'(beat_idx_o), exp_idx(s, k, ilv, wr, chop));
         else   chk("R4 idle index", int'(beat_idx_o), 0);
         chk("R4 drive enable", int'(drv_en_o), int'(v && !wr));
         chk("R8 done", int'(done_o), int'(k == BEATS - 1));
         chk("R9 overrun", int'(overrun_o), int'(dis >= 0 && k == dis + 1));
         if (k == dis) begin
            // R10: flip every config input together with the stray start
            start_i = 1'b1; col_i = ~IW'(s); ilv_i = !ilv; wr_i = !wr; chop_i = !chop;
         end
         if (k == dis + 1) start_i = 1'b0;
      end
      @(negedge clk);
      chk("R8 single done pulse", int'(done_o), 0);
      chk("R7 burst ended", int'(beat_vld_o), 0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; start_i = 1'b0; col_i = '0; ilv_i = 1'b0; wr_i = 1'b0; chop_i = 1'b0;
      repeat (3) @(negedge clk);
      chk("R1 reset index", int'(beat_idx_o), 0);
      chk("R1 reset valid", int'(beat_vld_o), 0);
      chk("R1 reset drive", int'(drv_en_o), 0);
      chk("R1 reset done", int'(done_o), 0);
      chk("R1 reset overrun", int'(overrun_o), 0);
      // start held during reset must not launch anything
      start_i = 1'b1;
      @(negedge clk);
      chk("R1 start in reset", int'(beat_vld_o), 0);
      start_i = 1'b0;
      rst_n = 1'b1;
      @(negedge clk);

      for (int w = 0; w < 2; w++)
         for (int c = 0; c < 2; c++)
            for (int m = 0; m < 2; m++)
               for (int s = 0; s < BEATS; s++)
                  run(s, bit'(m), bit'(w), bit'(c), -1);

      // R9 and R10: stray starts at first, middle and last-but-one check points
      run(5, 1'b0, 1'b0, 1'b0, 0);
      run(3, 1'b1, 1'b0, 1'b1, 6);
      run(6, 1'b0, 1'b1, 1'b1, 2);
      run(2, 1'b1, 1'b1, 1'b0, 4);
      run(7, 1'b0, 1'b0, 1'b1, 3);

      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

endmodule